// File: doc/BRIEF.md
# High-Speed UART Transmitter

This block is the sending half of a fast serial port with a fixed 8N1 frame. Bytes pushed through a small register write port queue in a 64-entry FIFO. A shift engine sends them on a single output line, which rests at logic 1 when nothing is being sent. Each bit lasts a whole multiple of 14 input clocks, and that multiple comes from an 8-bit rate register.

The control word holds four settings. A two-bit code selects when the transmit interrupt fires. A further bit gates the interrupt request. A break bit holds the line low. Two bits make character starts depend on a clear-to-send input and choose its polarity. The interrupt status bit is sticky and is cleared by writing a 1 to it. The current FIFO fill level is always visible on an output.

Top module: `hs_uart_tx`

## Requirements
- R1: After reset the line `tx_o` is 1, `tx_level_o` is 0 and `irq_o` is 0. While no character is in flight and break is off, the line stays at 1.
- R2: A character is a 0 start bit, then the 8 data bits least significant first, then a 1 stop bit. Each bit lasts (RATE+1)*14 clock cycles. The start bit shows on the line in the cycle after the character starts.
- R3: A write to word address 0 pushes `wr_data_i[7:0]` into the 64-entry FIFO. A push while 64 bytes are already held is dropped. `tx_level_o` gives the number of bytes held, and a byte leaves the FIFO when its character starts.
- R4: A write to word address 4 loads RATE from `wr_data_i[7:0]`. A character in flight keeps the rate that was in force when it started.
- R5: Control bits [1:0] pick the interrupt threshold: 0 means empty, 1 means 4 bytes, 2 means 8 bytes and 3 means 16 bytes. The status flag sets one cycle after the level moves from above the threshold to at or below it.
- R6: A write to word address 2 with bit 0 set clears the status flag. If a set event falls in the same cycle, the set wins.
- R7: `irq_o` is the status flag ANDed with control bit 5. A flag that is held while bit 5 is 0 shows on `irq_o` as soon as bit 5 is set.
- R8: While control bit 8 is 1, `tx_o` is 0 and no new character starts. When the bit is cleared, queued bytes are sent.
- R9: Control bit 14 makes starts depend on `cts_i`, after a 2-flop synchronizer. Permission is `cts_i` high, or `cts_i` low when control bit 15 is 1. A character in flight always completes.
- R10: When a byte is waiting and starting is permitted, the next start bit follows the last stop-bit cycle directly, with no idle cycle between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Word address: 0 FIFO, 2 status, 3 control, 4 rate |
| wr_data_i | input | 32 | Write data |
| cts_i | input | 1 | Clear-to-send input, asynchronous |
| tx_o | output | 1 | Serial output line |
| tx_level_o | output | 8 | Number of bytes in the FIFO |
| irq_o | output | 1 | Transmit interrupt request |

## Verification
The bench fills the FIFO past 64 bytes while the clear-to-send input blocks sending. A design that wrapped its pointers or counted past the limit would show a level other than 64, and the drain that follows would send the wrong bytes. The rate is changed in the middle of a stream of back-to-back characters. Applying the new rate inside the current bit, or leaving an idle cycle between frames, moves the line edges away from the cycle model. The interrupt flag is checked as the level drains through the 8-byte threshold, then cleared, then masked and unmasked. A level-sensitive flag would come back right after it is cleared, and a missing gate would raise the request while masked. Clear-to-send is dropped during a character and break is held with a byte queued. A design that cut the character short, or started a new one under break, would leave the level or the line at the wrong value.

// File: rtl/hs_uart_tx_pkg.sv
package hs_uart_tx_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned LVL_W  = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA  = 3'd0,
    A_LEVEL = 3'd1,
    A_STAT  = 3'd2,
    A_CTRL  = 3'd3,
    A_RATE  = 3'd4
  } reg_addr_e;

  localparam int unsigned C_IEN     = 5;
  localparam int unsigned C_BRK     = 8;
  localparam int unsigned C_CTS_EN  = 14;
  localparam int unsigned C_CTS_INV = 15;

  function automatic logic [LVL_W-1:0] thr_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return LVL_W'(0);
      2'd1:    return LVL_W'(4);
      2'd2:    return LVL_W'(8);
      default: return LVL_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/hs_uart_tx_fifo.sv
module hs_uart_tx_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DW-1:0]    din_i,
  input  logic             pop_i,
  output logic [DW-1:0]    dout_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign push_ok = push_i && (cnt_q != CNT_W'(DEPTH));
  assign pop_ok  = pop_i && (cnt_q != '0);

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= nxt(wp_q);
      if (pop_ok)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  assign dout_o  = mem[rp_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/hs_uart_tx_ser.sv
module hs_uart_tx_ser #(
  parameter int unsigned DW     = 8,
  parameter int unsigned OSR    = 14,
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DW-1:0]     data_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              line_o
);
  localparam int unsigned FRAME = DW + 2;
  localparam int unsigned IDX_W = $clog2(FRAME);
  localparam int unsigned PER_W = RATE_W + $clog2(OSR);

  logic [FRAME-1:0] sh_q;
  logic [IDX_W-1:0] idx_q;
  logic [PER_W-1:0] tick_q, per_q, per_d;
  logic             busy_q, last_tick;

  // bit length minus one, captured per character
  assign per_d = (PER_W'(rate_i) + PER_W'(1)) * PER_W'(OSR) - PER_W'(1);
  assign last_tick = (tick_q == per_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      idx_q  <= '0;
      tick_q <= '0;
      per_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      sh_q   <= {1'b1, data_i, 1'b0};
      idx_q  <= '0;
      tick_q <= '0;
      per_q  <= per_d;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (last_tick) begin
        tick_q <= '0;
        if (idx_q == IDX_W'(FRAME - 1)) begin
          busy_q <= 1'b0;
        end else begin
          sh_q  <= {1'b1, sh_q[FRAME-1:1]};
          idx_q <= idx_q + IDX_W'(1);
        end
      end else begin
        tick_q <= tick_q + PER_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && last_tick && (idx_q == IDX_W'(FRAME - 1));
  assign line_o = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/hs_uart_tx_irq.sv
module hs_uart_tx_irq
  import hs_uart_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic [1:0]       thr_i,
  input  logic             clr_i,
  input  logic             ien_i,
  output logic             set_o,
  output logic             pend_o,
  output logic             irq_o
);
  logic below, below_q, pend_q;

  assign below = (level_i <= thr_bytes(thr_i));
  assign set_o = below && !below_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      below_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      below_q <= below;
      pend_q  <= set_o || (pend_q && !clr_i);
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q && ien_i;
endmodule

// File: rtl/hs_uart_tx.sv
module hs_uart_tx
  import hs_uart_tx_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned OSR    = 14,
  parameter int unsigned RATE_W = 8,
  parameter int unsigned SYNC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  input  logic              cts_i,
  output logic              tx_o,
  output logic [LVL_W-1:0]  tx_level_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [RATE_W-1:0] rate_q;
  logic [1:0]        thr_q;
  logic              ien_q, brk_q, cts_en_q, cts_inv_q;
  logic [SYNC-1:0]   cts_q;
  logic              wr_fifo, wr_ctrl, wr_rate, stat_clr;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [DATA_W-1:0] fifo_dout;
  logic              cts_ok, can_go, start;
  logic              ser_busy, ser_done, ser_line;
  logic              irq_set, irq_pend;
  logic              unused_ok;

  assign wr_fifo  = wr_en_i && (wr_addr_i == A_DATA);
  assign wr_ctrl  = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_rate  = wr_en_i && (wr_addr_i == A_RATE);
  assign stat_clr = wr_en_i && (wr_addr_i == A_STAT) && wr_data_i[0];
  assign unused_ok = ^{wr_data_i[BUS_W-1:16], wr_data_i[13:9]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q    <= '0;
      thr_q     <= '0;
      ien_q     <= 1'b0;
      brk_q     <= 1'b0;
      cts_en_q  <= 1'b0;
      cts_inv_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        thr_q     <= wr_data_i[1:0];
        ien_q     <= wr_data_i[C_IEN];
        brk_q     <= wr_data_i[C_BRK];
        cts_en_q  <= wr_data_i[C_CTS_EN];
        cts_inv_q <= wr_data_i[C_CTS_INV];
      end
      if (wr_rate) rate_q <= wr_data_i[RATE_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cts_q <= '0;
    else         cts_q <= {cts_q[SYNC-2:0], cts_i};
  end

  assign cts_ok = !cts_en_q || (cts_q[SYNC-1] ^ cts_inv_q);
  assign can_go = (fifo_cnt != '0) && cts_ok && !brk_q;
  assign start  = can_go && (!ser_busy || ser_done);

  hs_uart_tx_fifo #(.DEPTH(DEPTH), .DW(DATA_W), .CNT_W(CNT_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_fifo),
    .din_i   (wr_data_i[DATA_W-1:0]),
    .pop_i   (start),
    .dout_o  (fifo_dout),
    .count_o (fifo_cnt)
  );

  hs_uart_tx_ser #(.DW(DATA_W), .OSR(OSR), .RATE_W(RATE_W)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .data_i  (fifo_dout),
    .rate_i  (rate_q),
    .busy_o  (ser_busy),
    .done_o  (ser_done),
    .line_o  (ser_line)
  );

  assign tx_level_o = LVL_W'(fifo_cnt);
  assign tx_o       = brk_q ? 1'b0 : ser_line;

  hs_uart_tx_irq u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (tx_level_o),
    .thr_i   (thr_q),
    .clr_i   (stat_clr),
    .ien_i   (ien_q),
    .set_o   (irq_set),
    .pend_o  (irq_pend),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/hs_uart_tx_chk.sv
module hs_uart_tx_chk
  import hs_uart_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_o,
  input logic [LVL_W-1:0] lvl_i,
  input logic             irq_i,
  input logic             busy_i,
  input logic             brk_i,
  input logic             ien_i,
  input logic             clr_i,
  input logic             set_i,
  input logic             pend_i
);
  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !brk_i) |-> tx_o);

  a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !tx_o);

  a_r3_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_i <= LVL_W'(DEPTH));

  a_r3_level_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i <= $past(lvl_i) + LVL_W'(1)) && ($past(lvl_i) <= lvl_i + LVL_W'(1)));

  a_r5_set_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_i);

  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !pend_i);

  a_r7_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_i |-> !irq_i);

  a_r8_break_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |-> !tx_o);
endmodule

bind hs_uart_tx hs_uart_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tx_o   (tx_o),
  .lvl_i  (tx_level_o),
  .irq_i  (irq_o),
  .busy_i (ser_busy),
  .brk_i  (brk_q),
  .ien_i  (ien_q),
  .clr_i  (stat_clr),
  .set_i  (irq_set),
  .pend_i (irq_pend)
);

// File: tb/hs_uart_tx_test.sv
`timescale 1ns/1ps
module hs_uart_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        cts = 1'b0;
  logic        tx;
  logic [7:0]  lvl;
  logic        irq;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit run = 0, ended = 0;

  always #2 clk = ~clk;

  hs_uart_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cts_i(cts), .tx_o(tx), .tx_level_o(lvl), .irq_o(irq)
  );

  // behavioural reference
  byte unsigned q[$];
  byte unsigned m_cur = 0;
  int m_busy = 0, m_tick = 0, m_per = 0, m_bit = 0;
  int m_rate = 0, m_thr = 0, m_ien = 0, m_brk = 0, m_cen = 0, m_inv = 0;
  int s1 = 0, s2 = 0, m_below = 1, m_pend = 0;
  int sz, tv, go, fin, okc, bel, st, cl;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_busy = 0; m_tick = 0; m_per = 0; m_bit = 0; m_rate = 0; m_thr = 0;
      m_ien = 0; m_brk = 0; m_cen = 0; m_inv = 0; s1 = 0; s2 = 0;
      m_below = 1; m_pend = 0;
    end else begin
      sz  = q.size();
      fin = (m_busy != 0 && m_tick == m_per && m_bit == 9) ? 1 : 0;
      okc = (m_cen == 0 || (s2 != m_inv)) ? 1 : 0;
      go  = (sz > 0 && okc != 0 && m_brk == 0 && (m_busy == 0 || fin != 0)) ? 1 : 0;
      tv  = (m_thr == 0) ? 0 : (m_thr == 1) ? 4 : (m_thr == 2) ? 8 : 16;
      bel = (sz <= tv) ? 1 : 0;
      st  = (bel != 0 && m_below == 0) ? 1 : 0;
      cl  = (wr_en && wr_addr == 3'd2 && wr_data[0]) ? 1 : 0;
      m_pend  = (st != 0 || (m_pend != 0 && cl == 0)) ? 1 : 0;
      m_below = bel;
      if (go != 0) begin
        m_cur = q.pop_front();
        m_busy = 1; m_bit = 0; m_tick = 0; m_per = (m_rate + 1) * 14 - 1;
      end else if (m_busy != 0) begin
        if (m_tick == m_per) begin
          m_tick = 0;
          if (m_bit == 9) m_busy = 0; else m_bit++;
        end else m_tick++;
      end
      if (wr_en && wr_addr == 3'd0 && sz < 64) q.push_back(wr_data[7:0]);
      if (wr_en && wr_addr == 3'd3) begin
        m_thr = int'(wr_data[1:0]); m_ien = int'(wr_data[5]); m_brk = int'(wr_data[8]);
        m_cen = int'(wr_data[14]); m_inv = int'(wr_data[15]);
      end
      if (wr_en && wr_addr == 3'd4) m_rate = int'(wr_data[7:0]);
      s2 = s1; s1 = int'(cts);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_line();
    if (m_brk != 0) return 0;
    if (m_busy == 0) return 1;
    if (m_bit == 0) return 0;
    if (m_bit == 9) return 1;
    return int'(m_cur[m_bit-1]);
  endfunction

  always @(negedge clk) begin
    if (run && !ended) begin
      check("R2 R4 R8 R9 R10 line", int'(tx), exp_line());
      check("R3 level", int'(lvl), q.size());
      check("R5 R6 R7 irq", int'(irq), m_pend & m_ien);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input int tail);
    for (int n = 0; n < 40000 && lvl != 8'd0; n++) @(negedge clk);
    idle(tail);
  endtask

  task automatic catch_byte(input int per, input int exp, input string tag);
    int got = 0;
    for (int n = 0; n < 20000 && tx !== 1'b0; n++) @(negedge clk);
    idle(per + per / 2);
    for (int i = 0; i < 8; i++) begin
      got |= int'(tx) << i;
      idle(per);
    end
    check(tag, got, exp);
    check({tag, " stop"}, int'(tx), 1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    run = 1;
    @(negedge clk);
    check("R1 reset line", int'(tx), 1);
    check("R1 reset level", int'(lvl), 0);
    check("R1 reset irq", int'(irq), 0);

    // R2 at rate 0, R5/R6/R7 on empty threshold
    wr(3, 32'h20);
    wr(4, 0);
    wr(0, 'hA5);
    catch_byte(14, 'hA5, "R2 byte rate0");
    idle(20);
    check("R5 R7 irq after empty", int'(irq), 1);
    wr(2, 1);
    check("R6 irq cleared", int'(irq), 0);
    wr(3, 0);
    wr(0, 'h5A);
    idle(200);
    check("R7 masked", int'(irq), 0);
    wr(3, 32'h20);
    check("R7 unmasked", int'(irq), 1);
    wr(2, 1);

    // R2 at rate 2
    wr(4, 2);
    wr(0, 'h3C);
    catch_byte(42, 'h3C, "R2 byte rate2");
    idle(60);
    wr(2, 1);

    // R3 overflow, R5 threshold 8, R4 rate change mid stream, R10 back to back
    cts = 1'b0;
    wr(3, (1 << 14) | (1 << 5) | 2);
    wr(4, 0);
    for (int i = 0; i < 66; i++) wr(0, i + 1);
    check("R3 full level", int'(lvl), 64);
    wr(2, 1);
    check("R5 no irq above threshold", int'(irq), 0);
    cts = 1'b1;
    idle(2003);
    wr(4, 1);
    for (int n = 0; n < 40000 && lvl != 8'd8; n++) @(negedge clk);
    idle(2);
    check("R5 irq at threshold 8", int'(irq), 1);
    drain(300);

    // R9 flow control
    wr(2, 1);
    wr(3, 1 << 14);
    wr(0, 'h11);
    wr(0, 'h22);
    wr(0, 'h33);
    cts = 1'b0;
    idle(400);
    check("R9 held level", int'(lvl), 2);
    check("R9 held line", int'(tx), 1);
    wr(3, (1 << 14) | (1 << 15));
    drain(320);
    check("R9 inverted drain", int'(lvl), 0);

    // R8 break
    wr(3, 1 << 8);
    check("R8 break low", int'(tx), 0);
    wr(0, 'h77);
    idle(60);
    check("R8 no start", int'(lvl), 1);
    check("R8 still low", int'(tx), 0);
    wr(3, 0);
    drain(320);
    check("R8 sent after release", int'(lvl), 0);

    ended = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule